// File: doc/BRIEF.md
# Multi-Mode Position Counter Core

This block is the counting core for one motion axis. A decoder ahead of it supplies a one-cycle count-enable pulse and a direction bit. On each accepted pulse the core steps a 24-bit register up or down, in plain binary or in six packed BCD digits. A 24-bit preset value sets the boundary for the active mode. The four boundary behaviours are free-running wrap, a clamp between zero and the preset, a one-shot stop after the first wrap, and a bidirectional divide-by-(preset+1) cycle.

Three active-low pulses, each one clock wide, report carry, borrow and compare events. An 8-bit status word keeps three toggle bits, a sign bit, a direction bit and two sticky latches. Control strobes reload the count from the preset, zero it, and clear status bits. The error and index latches are set by event inputs that come from the surrounding filter and index logic.

Top module: `pos_counter_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `count` is 0, `status` is 0x00 and `carry_n`, `borrow_n`, `compare_n` are all 1.
- R2: In mode 2'b00 (free), an up step from the top value (0xFFFFFF binary, 0x999999 BCD) gives 0 with a carry pulse, and a down step from 0 gives the top value with a borrow pulse. Every other step adds or subtracts one.
- R3: With `bcd` at 1, each 4-bit nibble counts 0 to 9 and ripples into the next nibble (0x000009+1 = 0x000010, 0x000100-1 = 0x000099). With `bcd` at 0 the count is plain binary.
- R4: In mode 2'b11 (modulo), an up step at `count == preset` gives 0 with a carry pulse, and a down step at 0 loads `preset` with a borrow pulse.
- R5: In mode 2'b01 (range), an up step at `count == preset` and a down step at 0 leave the count unchanged and raise no pulse. A step in the opposite direction moves it again.
- R6: In mode 2'b10 (one-shot), a wrap emits its carry or borrow and then blocks later steps. Only a load or a reset command lets counting resume.
- R7: A step that lands on `preset` gives a compare pulse in modes 00 and 10 in either direction. In modes 01 and 11 it gives the pulse only when counting up. A frozen step, a load and a reset never give one.
- R8: Status bit layout: [0] borrow toggle, [1] carry toggle, [2] compare toggle, [3] sign, [4] error latch, [5] last direction (1 = up), [6] index latch, [7] always 0. Each toggle inverts once per matching pulse.
- R9: The sign bit goes to 1 on every borrow and to 0 on every carry.
- R10: `err_evt` sets bit 4 and `idx_evt` sets bit 6. These bits hold until cleared by `cmd_clr_err` or `cmd_clr_flags` respectively, and a set in the same cycle as a clear wins.
- R11: `cmd_clr_flags` zeroes bits 0, 1, 2, 3 and 6, and leaves bits 4 and 5 unchanged.
- R12: `cmd_reset` outranks `cmd_load`, and both outrank a count pulse in the same cycle. The count becomes 0 or `preset` with no carry, borrow or compare pulse.
- R13: The pulses go low for exactly the cycle after the accepted step, together with the updated `count`. Carry and borrow are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | One-cycle count request |
| cnt_up | input | 1 | Step direction, 1 = up |
| mode | input | 2 | Boundary mode: 00 free, 01 range, 10 one-shot, 11 modulo |
| bcd | input | 1 | 1 = decimal digits, 0 = binary |
| preset | input | 24 | Preset / boundary value |
| cmd_load | input | 1 | Copy preset into the count |
| cmd_reset | input | 1 | Zero the count |
| cmd_clr_flags | input | 1 | Clear toggles, sign and index latch |
| cmd_clr_err | input | 1 | Clear error latch |
| err_evt | input | 1 | Set error latch |
| idx_evt | input | 1 | Set index latch |
| count | output | 24 | Current count |
| status | output | 8 | Status word |
| carry_n | output | 1 | Carry pulse, active low |
| borrow_n | output | 1 | Borrow pulse, active low |
| compare_n | output | 1 | Compare pulse, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first is a count request arriving together with a load or reset command. The second is a latch being set in the same cycle its clear command arrives. The bench raises a count step that would cross a boundary together with `cmd_load`, and another together with `cmd_reset`. It expects the commanded value with all three pulses still high. It also pulses `err_evt` with `cmd_clr_err`, and `idx_evt` with `cmd_clr_flags`, and expects the latch bit to remain 1 in the status word read on the next cycle.

// File: rtl/axcnt_pkg.sv
package axcnt_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'b00,
        MODE_RANGE   = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_MODULO  = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic carry;
        logic borrow;
        logic match;
    } cnt_evt_t;

    localparam int STATUS_W = 8;
    localparam int ST_BT    = 0;
    localparam int ST_CT    = 1;
    localparam int ST_CPT   = 2;
    localparam int ST_SIGN  = 3;
    localparam int ST_ERR   = 4;
    localparam int ST_DIR   = 5;
    localparam int ST_IDX   = 6;

    function automatic logic up_only_compare(cnt_mode_e m);
        return (m == MODE_MODULO) || (m == MODE_RANGE);
    endfunction

endpackage

// File: rtl/axcnt_arith.sv
module axcnt_arith #(
    parameter int W = 24
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] inc,
    output logic [W-1:0] dec,
    output logic [W-1:0] top,
    output logic         is_top,
    output logic         is_zero
);
    localparam int DIG = W / 4;

    logic [DIG:0]   cy;
    logic [DIG:0]   bw;
    logic [W-1:0]   inc_d;
    logic [W-1:0]   dec_d;

    assign cy[0] = 1'b1;
    assign bw[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < DIG; g++) begin : g_digit
            logic [3:0] d;
            assign d         = val[4*g +: 4];
            assign cy[g+1]   = cy[g] & (d == 4'd9);
            assign bw[g+1]   = bw[g] & (d == 4'd0);
            assign inc_d[4*g +: 4] = !cy[g] ? d : ((d == 4'd9) ? 4'd0 : d + 4'd1);
            assign dec_d[4*g +: 4] = !bw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        end
    endgenerate

    assign inc     = bcd ? inc_d : val + 1'b1;
    assign dec     = bcd ? dec_d : val - 1'b1;
    assign top     = bcd ? {DIG{4'h9}} : {W{1'b1}};
    assign is_top  = (val == top);
    assign is_zero = (val == '0);
endmodule

// File: rtl/axcnt_step.sv
module axcnt_step
    import axcnt_pkg::*;
#(
    parameter int W = 24
) (
    input  cnt_mode_e    mode,
    input  logic         bcd,
    input  logic         up,
    input  logic [W-1:0] count,
    input  logic [W-1:0] preset,
    output logic [W-1:0] nxt,
    output cnt_evt_t     evt,
    output logic         halt_set
);
    logic [W-1:0] inc, dec, top;
    logic         is_top, is_zero;
    logic         at_preset;
    logic         frozen;

    axcnt_arith #(.W(W)) u_arith (
        .val    (count),
        .bcd    (bcd),
        .inc    (inc),
        .dec    (dec),
        .top    (top),
        .is_top (is_top),
        .is_zero(is_zero)
    );

    assign at_preset = (count == preset);

    always_comb begin
        nxt        = count;
        evt.carry  = 1'b0;
        evt.borrow = 1'b0;
        frozen     = 1'b0;
        unique case (mode)
            MODE_MODULO: begin
                if (up) begin
                    if (at_preset) begin
                        nxt       = '0;
                        evt.carry = 1'b1;
                    end else begin
                        nxt = inc;
                    end
                end else begin
                    if (is_zero) begin
                        nxt        = preset;
                        evt.borrow = 1'b1;
                    end else begin
                        nxt = dec;
                    end
                end
            end
            MODE_RANGE: begin
                if (up) begin
                    if (at_preset) begin
                        frozen = 1'b1;
                    end else if (is_top) begin
                        nxt       = '0;
                        evt.carry = 1'b1;
                    end else begin
                        nxt = inc;
                    end
                end else begin
                    if (is_zero) frozen = 1'b1;
                    else         nxt    = dec;
                end
            end
            default: begin
                if (up) begin
                    if (is_top) begin
                        nxt       = '0;
                        evt.carry = 1'b1;
                    end else begin
                        nxt = inc;
                    end
                end else begin
                    if (is_zero) begin
                        nxt        = top;
                        evt.borrow = 1'b1;
                    end else begin
                        nxt = dec;
                    end
                end
            end
        endcase
        evt.match = !frozen && (nxt == preset) && (up || !up_only_compare(mode));
        halt_set  = (mode == MODE_ONESHOT) && (evt.carry || evt.borrow);
    end
endmodule

// File: rtl/axcnt_flags.sv
module axcnt_flags
    import axcnt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cnt_evt_t            evt,
    input  logic                cnt_en,
    input  logic                up,
    input  logic                clr_flags,
    input  logic                clr_err,
    input  logic                err_evt,
    input  logic                idx_evt,
    output logic [STATUS_W-1:0] status
);
    logic bt_q, ct_q, cpt_q, sgn_q, err_q, dir_q, idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bt_q  <= 1'b0;
            ct_q  <= 1'b0;
            cpt_q <= 1'b0;
            sgn_q <= 1'b0;
            err_q <= 1'b0;
            dir_q <= 1'b0;
            idx_q <= 1'b0;
        end else begin
            if (clr_flags) begin
                bt_q  <= 1'b0;
                ct_q  <= 1'b0;
                cpt_q <= 1'b0;
                sgn_q <= 1'b0;
            end else begin
                bt_q  <= bt_q  ^ evt.borrow;
                ct_q  <= ct_q  ^ evt.carry;
                cpt_q <= cpt_q ^ evt.match;
                if (evt.borrow)     sgn_q <= 1'b1;
                else if (evt.carry) sgn_q <= 1'b0;
            end
            if (err_evt)      err_q <= 1'b1;
            else if (clr_err) err_q <= 1'b0;
            if (idx_evt)        idx_q <= 1'b1;
            else if (clr_flags) idx_q <= 1'b0;
            if (cnt_en) dir_q <= up;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_BT]   = bt_q;
        status[ST_CT]   = ct_q;
        status[ST_CPT]  = cpt_q;
        status[ST_SIGN] = sgn_q;
        status[ST_ERR]  = err_q;
        status[ST_DIR]  = dir_q;
        status[ST_IDX]  = idx_q;
    end
endmodule

// File: rtl/pos_counter_core.sv
module pos_counter_core
    import axcnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic                cnt_up,
    input  logic [1:0]          mode,
    input  logic                bcd,
    input  logic [W-1:0]        preset,
    input  logic                cmd_load,
    input  logic                cmd_reset,
    input  logic                cmd_clr_flags,
    input  logic                cmd_clr_err,
    input  logic                err_evt,
    input  logic                idx_evt,
    output logic [W-1:0]        count,
    output logic [STATUS_W-1:0] status,
    output logic                carry_n,
    output logic                borrow_n,
    output logic                compare_n
);
    cnt_mode_e    mode_e;
    logic [W-1:0] cnt_q;
    logic         halt_q;
    logic [W-1:0] step_nxt;
    cnt_evt_t     evt_raw;
    cnt_evt_t     evt_acc;
    logic         halt_set;
    logic         take;
    logic         cy_n_q, bw_n_q, cp_n_q;

    assign mode_e = cnt_mode_e'(mode);

    axcnt_step #(.W(W)) u_step (
        .mode    (mode_e),
        .bcd     (bcd),
        .up      (cnt_up),
        .count   (cnt_q),
        .preset  (preset),
        .nxt     (step_nxt),
        .evt     (evt_raw),
        .halt_set(halt_set)
    );

    assign take    = cnt_en && !cmd_load && !cmd_reset && !halt_q;
    assign evt_acc = take ? evt_raw : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            halt_q <= 1'b0;
            cy_n_q <= 1'b1;
            bw_n_q <= 1'b1;
            cp_n_q <= 1'b1;
        end else begin
            if (cmd_reset) begin
                cnt_q  <= '0;
                halt_q <= 1'b0;
            end else if (cmd_load) begin
                cnt_q  <= preset;
                halt_q <= 1'b0;
            end else if (take) begin
                cnt_q <= step_nxt;
                if (halt_set) halt_q <= 1'b1;
            end
            cy_n_q <= ~evt_acc.carry;
            bw_n_q <= ~evt_acc.borrow;
            cp_n_q <= ~evt_acc.match;
        end
    end

    axcnt_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_acc),
        .cnt_en   (cnt_en),
        .up       (cnt_up),
        .clr_flags(cmd_clr_flags),
        .clr_err  (cmd_clr_err),
        .err_evt  (err_evt),
        .idx_evt  (idx_evt),
        .status   (status)
    );

    assign count     = cnt_q;
    assign carry_n   = cy_n_q;
    assign borrow_n  = bw_n_q;
    assign compare_n = cp_n_q;
endmodule

// File: rtl/axcnt_checks.sv
module axcnt_checks
    import axcnt_pkg::*;
#(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                cnt_en,
    input logic                cnt_up,
    input logic [1:0]          mode,
    input logic [W-1:0]        preset,
    input logic                cmd_load,
    input logic                cmd_reset,
    input logic                cmd_clr_flags,
    input logic                cmd_clr_err,
    input logic [W-1:0]        count,
    input logic [STATUS_W-1:0] status,
    input logic                carry_n,
    input logic                borrow_n,
    input logic                compare_n
);
    a_r13_no_dual_pulse: assert property (@(posedge clk) disable iff (rst)
        !(!carry_n && !borrow_n));

    a_r13_carry_cause: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> $past(cnt_en && cnt_up && !cmd_load && !cmd_reset));

    a_r12_reset_first: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (count == '0));

    a_r12_load_value: assert property (@(posedge clk) disable iff (rst)
        cmd_load && !cmd_reset |=> (count == $past(preset)));

    a_r5_freeze_top: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RANGE) && cnt_en && cnt_up && (count == preset)
        && !cmd_load && !cmd_reset |=> $stable(count));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        status[ST_ERR] && !cmd_clr_err |=> status[ST_ERR]);

    a_r9_sign_on_borrow: assert property (@(posedge clk) disable iff (rst)
        !borrow_n && !$past(cmd_clr_flags) |-> status[ST_SIGN]);

    a_r7_modulo_up_only: assert property (@(posedge clk) disable iff (rst)
        !compare_n && ($past(mode) == MODE_MODULO) |-> $past(cnt_up));
endmodule

bind pos_counter_core axcnt_checks #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_en       (cnt_en),
    .cnt_up       (cnt_up),
    .mode         (mode),
    .preset       (preset),
    .cmd_load     (cmd_load),
    .cmd_reset    (cmd_reset),
    .cmd_clr_flags(cmd_clr_flags),
    .cmd_clr_err  (cmd_clr_err),
    .count        (count),
    .status       (status),
    .carry_n      (carry_n),
    .borrow_n     (borrow_n),
    .compare_n    (compare_n)
);

// File: tb/pos_counter_core_test.sv
module pos_counter_core_test;
    localparam int W  = 24;
    localparam int VW = 58;
    localparam int NV = 33;

    logic         clk = 1'b0;
    logic         rst;
    logic         cnt_en, cnt_up, bcd;
    logic [1:0]   mode;
    logic [W-1:0] preset;
    logic         cmd_load, cmd_reset, cmd_clr_flags, cmd_clr_err;
    logic         err_evt, idx_evt;
    logic [W-1:0] count;
    logic [7:0]   status;
    logic         carry_n, borrow_n, compare_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pos_counter_core #(.W(W)) uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up), .mode(mode),
        .bcd(bcd), .preset(preset), .cmd_load(cmd_load), .cmd_reset(cmd_reset),
        .cmd_clr_flags(cmd_clr_flags), .cmd_clr_err(cmd_clr_err),
        .err_evt(err_evt), .idx_evt(idx_evt), .count(count), .status(status),
        .carry_n(carry_n), .borrow_n(borrow_n), .compare_n(compare_n)
    );

    // {mode, bcd, en, up, load, reset, preset, exp_count, exp carry_n, borrow_n, compare_n}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,24'h000005,24'h000000,3'b111},
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000005,24'h000001,3'b111},
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000005,24'h000000,3'b111},
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000005,24'hFFFFFF,3'b101},
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000005,24'h000000,3'b011},
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,24'h000005,24'h000005,3'b111},
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000005,24'h000006,3'b111},
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000005,24'h000005,3'b110},
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,24'h000002,24'h000000,3'b111},
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000002,24'h000001,3'b111},
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000002,24'h000002,3'b110},
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000002,24'h000000,3'b011},
        {2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000002,24'h000002,3'b101},
        {2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000002,24'h000001,3'b111},
        {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,24'h000003,24'h000003,3'b111},
        {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000003,24'h000003,3'b111},
        {2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000003,24'h000002,3'b111},
        {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,24'h000003,24'h000003,3'b110},
        {2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,24'h000003,24'h000000,3'b111},
        {2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,24'h000003,24'h000000,3'b111},
        {2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,24'h000000,24'h000000,3'b111},
        {2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,24'h000000,24'h999999,3'b101},
        {2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,24'h000000,24'h999999,3'b111},
        {2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,24'h000009,24'h000009,3'b111},
        {2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,24'h000009,24'h000010,3'b111},
        {2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,24'h000009,24'h000009,3'b110},
        {2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,24'h999999,24'h999999,3'b111},
        {2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,24'h999999,24'h000000,3'b011},
        {2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,24'h999999,24'h000000,3'b111},
        {2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,24'h000100,24'h000100,3'b111},
        {2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,24'h000100,24'h000099,3'b111},
        {2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,24'h000100,24'h000100,3'b111},
        {2'd0,1'b1,1'b1,1'b1,1'b0,1'b1,24'h000100,24'h000000,3'b111}
    };

    // Vectors 0-7 R2 (compare R7), 8-13 R4, 14-19 R5, 20-28 R6, 29-30 R3, 31-32 R12
    function automatic string req_of(int i);
        if (i < 8)  return "R2/R7";
        if (i < 14) return "R4/R7";
        if (i < 20) return "R5";
        if (i < 29) return "R6/R3";
        if (i < 31) return "R3";
        return "R12";
    endfunction

    task automatic idle();
        cnt_en = 0; cnt_up = 0; cmd_load = 0; cmd_reset = 0;
        cmd_clr_flags = 0; cmd_clr_err = 0; err_evt = 0; idx_evt = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        rst = 1; mode = 0; bcd = 0; preset = 0;
        idle();
        repeat (3) @(negedge clk);
        // R1: state during reset
        check_val("R1", "count in reset", {8'd0, count}, 32'd0);
        check_val("R1", "pulses in reset", {29'd0, carry_n, borrow_n, compare_n}, 32'd7);
        rst = 0;
        tick();
        check_val("R1", "status after reset", {24'd0, status}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            idle();
            mode = v[57:56]; bcd = v[55]; cnt_en = v[54]; cnt_up = v[53];
            cmd_load = v[52]; cmd_reset = v[51]; preset = v[50:27];
            tick();
            check_val(req_of(i), $sformatf("vector %0d count", i), {8'd0, count}, {8'd0, v[26:3]});
            check_val("R13", $sformatf("vector %0d pulses", i),
                      {29'd0, carry_n, borrow_n, compare_n}, {29'd0, v[2:0]});
        end

        // Directed status tests
        idle();
        rst = 1; tick(); rst = 0;
        check_val("R1", "status after second reset", {24'd0, status}, 32'd0);
        mode = 2'd0; bcd = 0; preset = 24'd0;
        cnt_en = 1; cnt_up = 0; tick(); idle();
        check_val("R8", "status after borrow", {24'd0, status}, 32'h09);
        check_val("R9", "sign after borrow", {31'd0, status[3]}, 32'd1);
        cnt_en = 1; cnt_up = 1; tick(); idle();
        check_val("R8", "status after carry onto preset", {24'd0, status}, 32'h27);
        check_val("R7", "compare pulse landing on 0", {31'd0, compare_n}, 32'd0);
        tick();
        check_val("R13", "pulse one clock wide", {29'd0, carry_n, borrow_n, compare_n}, 32'd7);
        err_evt = 1; tick(); idle();
        check_val("R10", "error latch set", {24'd0, status}, 32'h37);
        idx_evt = 1; tick(); idle();
        tick();
        check_val("R10", "index latch held", {24'd0, status}, 32'h77);
        cmd_clr_flags = 1; tick(); idle();
        check_val("R11", "clear flags keeps bits 4,5", {24'd0, status}, 32'h30);
        cmd_clr_err = 1; err_evt = 1; tick(); idle();
        check_val("R10", "error set wins over clear", {24'd0, status}, 32'h30);
        cmd_clr_err = 1; tick(); idle();
        check_val("R10", "error cleared by command", {24'd0, status}, 32'h20);
        cmd_clr_flags = 1; idx_evt = 1; tick(); idle();
        check_val("R10", "index set wins over clear", {24'd0, status}, 32'h60);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule